// File: doc/BRIEF.md
# Register-Mapped Parallel Port Controller

This block gives a processor byte-wide access to three parallel ports: two 8-bit ports (A and B) and one 6-bit port (C). It also gives access to a command register, a status word and the two count bytes of an external timer. The processor selects a location with a 3-bit register address and uses separate read and write strobes. The command register and the status word share location 0. A write reaches the command register, and a read returns the status word.

The command register sets the direction of ports A and B and the interrupt enables. It also selects the function of port C:
- plain input,
- plain output,
- handshake lines for port A only, with the upper half as outputs,
- handshake lines for both ports.

In handshake modes the interrupt-request and buffer-full flags come from an external handshake block. They are driven out on port C, and the strobe pins are passed back to that block. The timer is also outside this block. It receives the command bits 7:6 and the byte-write strobes, and it reports terminal count with a one-cycle pulse.

Top module: `pio_hub`

## Requirements
- R1: While reset is asserted, and once it is released, the command state is clear. Then `pa_oe`, `pb_oe`, `pc_oe`, `ie_a` and `ie_b` are 0, the port A, B and C latches are 0, the terminal-count flag is 0 and `rdata` is 0.
- R2: A read strobe at address `addr` places that location's value on `rdata` after the next rising clock edge. `rdata` holds that value until the next read. The address map is:
  - 0: status (read) or command (write)
  - 1: port A
  - 2: port B
  - 3: port C
  - 4: timer low byte
  - 5: timer high byte
  - 6 and 7: read as 0
- R3: Command bit 0 drives `pa_oe` and command bit 1 drives `pb_oe`. In both cases 1 means output and 0 means input.
- R4: A write to address 1, 2 or 3 updates that port's latch, whatever the port's direction. Port A and B latches drive `pa_out` and `pb_out` directly.
- R5: Reading port A or B returns its latch when the port is an output, and returns the input pins sampled in the read cycle when the port is an input.
- R6: Command bits 3:2 set `pc_oe` as follows:
  - 00: 6'b000000
  - 01: 6'b111111
  - 10: 6'b111011
  - 11: 6'b011011
  In modes 00 and 01, `pc_out` equals the port C latch.
- R7: In modes 10 and 11, port C carries the port A handshake: PC0 is interrupt A, PC1 is buffer-full A, and PC2 is the active-low strobe A input, which appears on `stb_a_n`. In mode 11, PC3, PC4 and PC5 carry the same three roles for port B, and PC5 appears on `stb_b_n`. In mode 10, PC3..PC5 come from the latch and PC2 is driven 0. Otherwise each strobe output is 1. Reading port C returns, bit by bit, the driven value for output bits and the pin for input bits, with bits 7:6 zero.
- R8: Command bit 4 drives `ie_a` and command bit 5 drives `ie_b`.
- R9: The status word has the following bits, with bit 7 zero:
  - bit 0: interrupt A
  - bit 1: buffer-full A
  - bit 2: enable A
  - bit 3: interrupt B
  - bit 4: buffer-full B
  - bit 5: enable B
  - bit 6: terminal-count flag
- R10: A `tmr_tc` pulse sets the terminal-count flag. A status read returns the flag's value from before that cycle and then clears it. If a `tmr_tc` pulse arrives in the same cycle as the status read, the flag stays set.
- R11: In the same cycle as the write strobe:
  - A write to address 0 raises `tmr_cmd_wr` and presents `wdata[7:6]` on `tmr_cmd`.
  - A write to address 4 raises `tmr_lo_wr`.
  - A write to address 5 raises `tmr_hi_wr`.
  Reads of addresses 4 and 5 return `tmr_lo_rd` and `tmr_hi_rd`.
- R12: Writes to addresses 6 and 7 change no port latch, direction or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A latch out |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B latch out |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pins in |
| pc_out | output | 6 | Port C driven values |
| pc_oe | output | 6 | Port C per-bit output enables |
| hs_a_intr | input | 1 | Interrupt request A from handshake logic |
| hs_a_bf | input | 1 | Buffer-full A from handshake logic |
| hs_b_intr | input | 1 | Interrupt request B from handshake logic |
| hs_b_bf | input | 1 | Buffer-full B from handshake logic |
| stb_a_n | output | 1 | Strobe A pin to handshake logic |
| stb_b_n | output | 1 | Strobe B pin to handshake logic |
| ie_a | output | 1 | Interrupt enable A |
| ie_b | output | 1 | Interrupt enable B |
| tmr_cmd | output | 2 | Timer command field |
| tmr_cmd_wr | output | 1 | Timer command strobe |
| tmr_lo_wr | output | 1 | Timer low byte write strobe |
| tmr_hi_wr | output | 1 | Timer high byte write strobe |
| tmr_lo_rd | input | 8 | Timer low byte read value |
| tmr_hi_rd | input | 8 | Timer high byte read value |
| tmr_tc | input | 1 | Terminal-count pulse |

## Verification
Some behaviours are checked by the assertions on every cycle:
- command writes reaching the direction, enable and port C enable outputs one cycle later;
- the port A latch staying still without a write to it;
- `rdata` holding between reads;
- the terminal-count flag being set by a pulse and cleared by a status read.

Other behaviours only the bench scenarios show:
- what a read returns for each direction and port C mode;
- the bit-by-bit layout of port C in the handshake modes;
- the status bit order;
- the tie between a terminal-count pulse and a status read in the same cycle;
- the absence of any effect from writes to the unused addresses.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int DATA_W = 8;
    localparam int PC_W   = 6;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] LOC_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] LOC_PA  = 3'd1;
    localparam logic [ADDR_W-1:0] LOC_PB  = 3'd2;
    localparam logic [ADDR_W-1:0] LOC_PC  = 3'd3;
    localparam logic [ADDR_W-1:0] LOC_TLO = 3'd4;
    localparam logic [ADDR_W-1:0] LOC_THI = 3'd5;

    typedef enum logic [1:0] {
        PCM_IN   = 2'b00,
        PCM_OUT  = 2'b01,
        PCM_HSA  = 2'b10,
        PCM_HSAB = 2'b11
    } pc_mode_e;

    typedef struct packed {
        logic     ie_b;
        logic     ie_a;
        pc_mode_e pc_mode;
        logic     dir_b;
        logic     dir_a;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic [DATA_W-1:0] pa;
        logic [DATA_W-1:0] pb;
        logic [PC_W-1:0]   pc;
        logic              tc;
        logic [DATA_W-1:0] rdata;
    } regs_t;

endpackage

// File: rtl/pio_pc_mux.sv
module pio_pc_mux
    import pio_pkg::*;
(
    input  pc_mode_e        mode,
    input  logic [PC_W-1:0] pc_lat,
    input  logic [PC_W-1:0] pc_in,
    input  logic            intr_a,
    input  logic            bf_a,
    input  logic            intr_b,
    input  logic            bf_b,
    output logic [PC_W-1:0] pc_out,
    output logic [PC_W-1:0] pc_oe,
    output logic [PC_W-1:0] pc_rd,
    output logic            stb_a_n,
    output logic            stb_b_n
);

    logic [PC_W-1:0] drv;
    logic [PC_W-1:0] oe;

    always_comb begin
        case (mode)
            PCM_IN: begin
                oe  = '0;
                drv = pc_lat;
            end
            PCM_OUT: begin
                oe  = '1;
                drv = pc_lat;
            end
            PCM_HSA: begin
                oe  = 6'b111011;
                drv = {pc_lat[5:3], 1'b0, bf_a, intr_a};
            end
            default: begin
                oe  = 6'b011011;
                drv = {1'b0, bf_b, intr_b, 1'b0, bf_a, intr_a};
            end
        endcase
        stb_a_n = (mode == PCM_HSA || mode == PCM_HSAB) ? pc_in[2] : 1'b1;
        stb_b_n = (mode == PCM_HSAB) ? pc_in[5] : 1'b1;
    end

    assign pc_out = drv;
    assign pc_oe  = oe;

    for (genvar i = 0; i < PC_W; i++) begin : g_rdbit
        assign pc_rd[i] = oe[i] ? drv[i] : pc_in[i];
    end

endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
    import pio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    input  logic              tc,
    input  logic              intr_a,
    input  logic              bf_a,
    input  logic              intr_b,
    input  logic              bf_b,
    input  logic [DATA_W-1:0] pa_lat,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_lat,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [PC_W-1:0]   pc_rd,
    input  logic [DATA_W-1:0] tmr_lo,
    input  logic [DATA_W-1:0] tmr_hi,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] status;

    assign status = {{(DATA_W-7){1'b0}}, tc,
                     cfg.ie_b, bf_b, intr_b,
                     cfg.ie_a, bf_a, intr_a};

    always_comb begin
        case (addr)
            LOC_CTL: rd_val = status;
            LOC_PA:  rd_val = cfg.dir_a ? pa_lat : pa_in;
            LOC_PB:  rd_val = cfg.dir_b ? pb_lat : pb_in;
            LOC_PC:  rd_val = {{(DATA_W-PC_W){1'b0}}, pc_rd};
            LOC_TLO: rd_val = tmr_lo;
            LOC_THI: rd_val = tmr_hi;
            default: rd_val = '0;
        endcase
    end

endmodule

// File: rtl/pio_hub.sv
module pio_hub
    import pio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [DATA_W-1:0]    pa_in,
    output logic [DATA_W-1:0]    pa_out,
    output logic                 pa_oe,
    input  logic [DATA_W-1:0]    pb_in,
    output logic [DATA_W-1:0]    pb_out,
    output logic                 pb_oe,
    input  logic [PC_W-1:0]      pc_in,
    output logic [PC_W-1:0]      pc_out,
    output logic [PC_W-1:0]      pc_oe,
    input  logic                 hs_a_intr,
    input  logic                 hs_a_bf,
    input  logic                 hs_b_intr,
    input  logic                 hs_b_bf,
    output logic                 stb_a_n,
    output logic                 stb_b_n,
    output logic                 ie_a,
    output logic                 ie_b,
    output logic [1:0]           tmr_cmd,
    output logic                 tmr_cmd_wr,
    output logic                 tmr_lo_wr,
    output logic                 tmr_hi_wr,
    input  logic [DATA_W-1:0]    tmr_lo_rd,
    input  logic [DATA_W-1:0]    tmr_hi_rd,
    input  logic                 tmr_tc
);

    regs_t             r_q, r_d;
    logic [PC_W-1:0]   pc_rd;
    logic [DATA_W-1:0] rd_val;
    logic              ctl_rd;

    assign ctl_rd = rd_en && (addr == LOC_CTL);

    pio_pc_mux u_pcmux (
        .mode    (r_q.cfg.pc_mode),
        .pc_lat  (r_q.pc),
        .pc_in   (pc_in),
        .intr_a  (hs_a_intr),
        .bf_a    (hs_a_bf),
        .intr_b  (hs_b_intr),
        .bf_b    (hs_b_bf),
        .pc_out  (pc_out),
        .pc_oe   (pc_oe),
        .pc_rd   (pc_rd),
        .stb_a_n (stb_a_n),
        .stb_b_n (stb_b_n)
    );

    pio_rd_mux u_rdmux (
        .addr   (addr),
        .cfg    (r_q.cfg),
        .tc     (r_q.tc),
        .intr_a (hs_a_intr),
        .bf_a   (hs_a_bf),
        .intr_b (hs_b_intr),
        .bf_b   (hs_b_bf),
        .pa_lat (r_q.pa),
        .pa_in  (pa_in),
        .pb_lat (r_q.pb),
        .pb_in  (pb_in),
        .pc_rd  (pc_rd),
        .tmr_lo (tmr_lo_rd),
        .tmr_hi (tmr_hi_rd),
        .rd_val (rd_val)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                LOC_CTL: r_d.cfg = cfg_t'(wdata[5:0]);
                LOC_PA:  r_d.pa  = wdata;
                LOC_PB:  r_d.pb  = wdata;
                LOC_PC:  r_d.pc  = wdata[PC_W-1:0];
                default: ;
            endcase
        end
        if (rd_en)  r_d.rdata = rd_val;
        if (ctl_rd) r_d.tc    = 1'b0;
        if (tmr_tc) r_d.tc    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata      = r_q.rdata;
    assign pa_out     = r_q.pa;
    assign pb_out     = r_q.pb;
    assign pa_oe      = r_q.cfg.dir_a;
    assign pb_oe      = r_q.cfg.dir_b;
    assign ie_a       = r_q.cfg.ie_a;
    assign ie_b       = r_q.cfg.ie_b;
    assign tmr_cmd    = wdata[7:6];
    assign tmr_cmd_wr = wr_en && (addr == LOC_CTL);
    assign tmr_lo_wr  = wr_en && (addr == LOC_TLO);
    assign tmr_hi_wr  = wr_en && (addr == LOC_THI);

    AST_DIR_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LOC_CTL) |=> (pa_oe == $past(wdata[0]) && pb_oe == $past(wdata[1]))); // R3

    AST_IE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LOC_CTL) |=> (ie_a == $past(wdata[4]) && ie_b == $past(wdata[5]))); // R8

    AST_PC_HSAB_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LOC_CTL && wdata[3:2] == 2'b11) |=> (pc_oe == 6'b011011)); // R6

    AST_PA_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == LOC_PA) |=> $stable(pa_out)); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2

    AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tc |=> r_q.tc); // R10

    AST_TC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !tmr_tc) |=> !r_q.tc); // R10

endmodule

// File: tb/pio_hub_test.sv
`timescale 1ns/1ps
module pio_hub_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'hA5;
    logic [7:0] pa_out;
    logic       pa_oe;
    logic [7:0] pb_in = 8'h3C;
    logic [7:0] pb_out;
    logic       pb_oe;
    logic [5:0] pc_in = 6'h2A;
    logic [5:0] pc_out;
    logic [5:0] pc_oe;
    logic       hs_a_intr = 1'b0;
    logic       hs_a_bf = 1'b0;
    logic       hs_b_intr = 1'b0;
    logic       hs_b_bf = 1'b0;
    logic       stb_a_n, stb_b_n, ie_a, ie_b;
    logic [1:0] tmr_cmd;
    logic       tmr_cmd_wr, tmr_lo_wr, tmr_hi_wr;
    logic [7:0] tmr_lo_rd = 8'h11;
    logic [7:0] tmr_hi_rd = 8'h22;
    logic       tmr_tc = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_hub uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .hs_a_intr(hs_a_intr), .hs_a_bf(hs_a_bf),
        .hs_b_intr(hs_b_intr), .hs_b_bf(hs_b_bf),
        .stb_a_n(stb_a_n), .stb_b_n(stb_b_n), .ie_a(ie_a), .ie_b(ie_b),
        .tmr_cmd(tmr_cmd), .tmr_cmd_wr(tmr_cmd_wr),
        .tmr_lo_wr(tmr_lo_wr), .tmr_hi_wr(tmr_hi_wr),
        .tmr_lo_rd(tmr_lo_rd), .tmr_hi_rd(tmr_hi_rd), .tmr_tc(tmr_tc)
    );

    // vector: {is_write, addr[2:0], wdata[7:0], expected read[7:0]}
    localparam int NVEC = 21;
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {1'b0, 3'd0, 8'h00, 8'h00},  // status after reset
        {1'b0, 3'd1, 8'h00, 8'hA5},  // A input: pins
        {1'b1, 3'd1, 8'h5A, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'hA5},  // still input
        {1'b1, 3'd0, 8'h03, 8'h00},  // A,B outputs
        {1'b0, 3'd1, 8'h00, 8'h5A},  // latch
        {1'b1, 3'd2, 8'hC3, 8'h00},
        {1'b0, 3'd2, 8'h00, 8'hC3},
        {1'b0, 3'd3, 8'h00, 8'h2A},  // C input
        {1'b1, 3'd3, 8'h15, 8'h00},
        {1'b1, 3'd0, 8'h07, 8'h00},  // C output
        {1'b0, 3'd3, 8'h00, 8'h15},
        {1'b0, 3'd4, 8'h00, 8'h11},
        {1'b0, 3'd5, 8'h00, 8'h22},
        {1'b0, 3'd6, 8'h00, 8'h00},
        {1'b1, 3'd0, 8'h0B, 8'h00},  // C mode 10
        {1'b0, 3'd3, 8'h00, 8'h10},
        {1'b1, 3'd0, 8'h33, 8'h00},  // enables on
        {1'b0, 3'd0, 8'h00, 8'h24},
        {1'b1, 3'd7, 8'hFF, 8'h00},  // ignored
        {1'b0, 3'd1, 8'h00, 8'h5A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pa_oe", pa_oe, 0);
        check("R1 pb_oe", pb_oe, 0);
        check("R1 pc_oe", pc_oe, 0);
        check("R1 ie", {ie_a, ie_b}, 0);
        check("R1 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pa_out", pa_out, 0);

        // R2 R4 R5 R6 R12 table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) do_wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                do_rd(VEC[i][18:16], v);
                check($sformatf("R2/R5 vec %0d", i), v, VEC[i][7:0]);
            end
        end
        check("R4 pb_out", pb_out, 8'hC3);
        check("R12 pa_out after addr7 write", pa_out, 8'h5A);
        check("R12 enables after addr7 write", {ie_b, ie_a, pb_oe, pa_oe}, 4'b1111);

        // R10 terminal count
        @(negedge clk); tmr_tc = 1'b1;
        @(negedge clk); tmr_tc = 1'b0;
        do_rd(3'd0, v); check("R10 R9 tc set", v, 8'h64);
        do_rd(3'd0, v); check("R10 tc cleared", v, 8'h24);
        @(negedge clk); rd_en = 1'b1; addr = 3'd0; tmr_tc = 1'b1;
        @(negedge clk); rd_en = 1'b0; tmr_tc = 1'b0; v = rdata;
        check("R10 same-cycle read old", v, 8'h24);
        do_rd(3'd0, v); check("R10 same-cycle set kept", v, 8'h64);
        repeat (3) @(negedge clk);
        check("R2 rdata held", rdata, 8'h64);

        // R11 timer strobes
        @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = 8'hC0;
        #1;
        check("R11 cmd strobe", {tmr_cmd_wr, tmr_lo_wr, tmr_hi_wr}, 3'b100);
        check("R11 cmd field", tmr_cmd, 2'd3);
        @(negedge clk); addr = 3'd4; wdata = 8'h77;
        #1;
        check("R11 lo strobe", {tmr_cmd_wr, tmr_lo_wr, tmr_hi_wr}, 3'b010);
        @(negedge clk); addr = 3'd5;
        #1;
        check("R11 hi strobe", {tmr_cmd_wr, tmr_lo_wr, tmr_hi_wr}, 3'b001);
        @(negedge clk); wr_en = 1'b0;
        check("R3 dirs after cmd C0", {pb_oe, pa_oe}, 2'b00);
        check("R8 enables after cmd C0", {ie_b, ie_a}, 2'b00);

        // R6 R7 mode 10
        pc_in = 6'b000000;
        do_wr(3'd0, 8'h08);
        check("R6 mode10 oe", pc_oe, 6'b111011);
        check("R7 mode10 stb", {stb_b_n, stb_a_n}, 2'b10);
        check("R7 mode10 out", pc_out, {3'b010, 3'b000});

        // R7 R9 mode 11
        do_wr(3'd0, 8'h0C);
        hs_a_intr = 1'b1; hs_b_bf = 1'b1;
        #1;
        check("R6 mode11 oe", pc_oe, 6'b011011);
        check("R7 mode11 out", pc_out, 6'b010001);
        check("R7 mode11 stb", {stb_b_n, stb_a_n}, 2'b00);
        do_rd(3'd0, v); check("R9 status hs", v, 8'h11);
        do_rd(3'd3, v); check("R7 portC read", v, 8'h11);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 re-reset dirs", {pc_oe, pb_oe, pa_oe}, 8'h00);
        check("R1 re-reset latches", {pa_out, pb_out}, 16'h0000);
        check("R1 re-reset rdata", rdata, 0);
        rst_n = 1'b1;
        hs_a_intr = 1'b0; hs_b_bf = 1'b0;
        do_rd(3'd0, v); check("R1 tc flag clear", v, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule